// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the timing strobes for a parallel LCD panel: a pixel clock enable, a line sync, a frame sync, a data-enable, a frame-start pulse and the pixel column and line indices that the data path uses to fetch and place pixels. It works in the core clock domain. The pixel rate is set by a divider, which can also be bypassed. Every horizontal and vertical phase length comes from a programmed field. The fields do not share one encoding: the line-sync width, the active sizes and all horizontal porches are stored as the count minus one, while the vertical porches are stored as plain line counts and may be zero.

A line is made of the sync pulse, then the back porch, then the active pixels, then the front porch. A frame uses the same order, counted in lines. The timing fields, the polarity bits, the display-type bit and the bits-per-pixel code are captured into shadow registers at the first pixel of every frame, so a write in the middle of a frame cannot tear the output. Power-up starts a frame at once. Power-down is a guarded sequence: the generator finishes the current frame and then a programmed number of further whole frames. It reports busy until the last of those frames has ended, and then goes idle.

Top module: `lcd_sync_gen`

## Requirements
- R1: During reset, and while idle with the power enable low, busy, pix_en, de and frame_start are 0, pix_x and line_y are 0, and hsync and vsync sit at their inactive level, which is the live value of hsync_inv and vsync_inv (0 means the pulse is high-true).
- R2: With bypass clear, pix_en pulses once every 2 × (div_val + 1) core cycles while busy, and never on two consecutive cycles.
- R3: With bypass set, pix_en is high on every core cycle while busy.
- R4: Each line has hs_width_m1+1 sync pixels, then hbp_m1+1 back-porch pixels, then h_act_m1+1 active pixels, then hfp_m1+1 front-porch pixels. The line sync is asserted only during the sync pixels.
- R5: Each frame has vs_width_m1+1 sync lines, then vbp_lines back-porch lines, then v_act_m1+1 active lines, then vfp_lines front-porch lines. Either vertical porch may be 0. The frame sync is asserted only during the sync lines.
- R6: de is 1 only when both the horizontal and the vertical position are inside the active region. pix_x is the column index from 0 during horizontal active pixels and 0 elsewhere. line_y is the row index from 0 during vertical active lines and 0 elsewhere.
- R7: While running, an inversion bit of 1 makes its sync output low during the pulse and high otherwise.
- R8: Timing fields, inversion bits, tft_sel and bpp_sel (a 3-bit code) are sampled at power-up and at the end of each frame. A change in mid-frame first shows in the next frame, and disp_tft and disp_bpp report the sampled values.
- R9: frame_start is high together with the pix_en of the first pixel (sync line 0, sync pixel 0) of every frame and at no other time.
- R10: After pwr_en falls, the current frame finishes and then exactly guard_frames further whole frames run. busy stays 1 until the last pix_en of the last of these frames and is 0 from the next cycle.
- R11: After busy falls, no pix_en is produced, de is 0 and both syncs hold the inactive level until pwr_en is raised again.
- R12: Raising pwr_en again during the guard frames resumes normal running without busy ever dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Power enable; 1 runs the generator, 0 starts the guarded stop |
| guard_frames | input | GUARD_W | Whole frames that run after the current one when stopping |
| div_val | input | DIV_W | Divider value; pixel period is 2 × (div_val + 1) cycles |
| div_bypass | input | 1 | 1 makes every core cycle a pixel |
| hs_width_m1 | input | H_FLD_W | Line-sync width in pixels minus one |
| hbp_m1 | input | H_FLD_W | Horizontal back porch in pixels minus one |
| hfp_m1 | input | H_FLD_W | Horizontal front porch in pixels minus one |
| h_act_m1 | input | H_ACT_W | Active columns minus one |
| vs_width_m1 | input | V_FLD_W | Frame-sync width in lines minus one |
| vbp_lines | input | V_FLD_W | Vertical back porch in lines (0 allowed) |
| vfp_lines | input | V_FLD_W | Vertical front porch in lines (0 allowed) |
| v_act_m1 | input | V_ACT_W | Active rows minus one |
| hsync_inv | input | 1 | 1 inverts the line sync |
| vsync_inv | input | 1 | 1 inverts the frame sync |
| tft_sel | input | 1 | Display type select, sampled per frame |
| bpp_sel | input | 3 | Bits-per-pixel code, sampled per frame |
| pix_en | output | 1 | Pixel clock enable, one core cycle wide |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_x | output | H_ACT_W | Active column index |
| line_y | output | V_ACT_W | Active row index |
| frame_start | output | 1 | Marks the pix_en of the first pixel of a frame |
| busy | output | 1 | High from power-up until the guarded stop ends |
| disp_tft | output | 1 | Display type in force for the current frame |
| disp_bpp | output | 3 | Bits-per-pixel code in force for the current frame |

## Verification
The scoreboard predicts every pixel of every frame (sync levels, de, indices, frame_start and the sampled display fields) from the raw field values. A design that added one to the vertical porches, or forgot to add one to a horizontal porch, shifts every later pixel and fails at once. A frame with both vertical porches set to zero and a bypassed divider checks that zero-length phases are skipped and that a pixel comes every cycle; a wrong divider shows up as a pixel period that differs from 2 × (div_val + 1). Timing and polarity are rewritten in the middle of a frame, so a design without shadow registers tears that frame. The power-down runs count frame starts between the fall of pwr_en and the fall of busy. They catch a guard that stops a frame too early or too late, a busy flag that falls in mid-frame, and a design that drops busy when pwr_en comes back during the guard.

// File: rtl/lcd_sync_pkg.sv
// Package: shared types of the LCD sync timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package lcd_sync_pkg;

    // Power sequencer states.
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_RUN   = 2'd1,
        PS_GUARD = 2'd2
    } pwr_state_t;

endpackage

// File: rtl/lcd_pixclk_div.sv
// Module: pixel clock enable divider.
// Produces a one-cycle tick every 2*(div_val+1) core cycles while run is
// high, or a tick on every cycle in bypass. The count restarts from zero
// whenever run is low, so the first pixel after power-up is a full period.
// Assumes: div_val may change at any time; the counter wraps at or above
// the new limit, so a shortened period never overruns.
module lcd_pixclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bypass,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Last count of a period: 2*div_val + 1.
    assign limit = {div_val, 1'b1};

    // Tick on the last count, or always when bypassed.
    assign tick = run && (bypass || (cnt == limit));

    // Period counter, held at zero while stopped or bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || bypass) begin
            cnt <= '0;
        end else if (cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lcd_axis_ctr.sv
// Module: one timing axis (horizontal in pixels or vertical in lines).
// Counts a period made of sync, back porch, active and front porch, in that
// order, and decodes the position into sync / active flags and an active
// index. Sync and active lengths are always encoded minus one; PORCH_M1
// picks whether the porch fields are minus-one encoded (1) or plain
// counts that may be zero (0).
// Assumes: FLD_W <= ACT_W so the period fits in ACT_W+2 bits; fields are
// stable while the axis counts (the top feeds it shadow registers).
module lcd_axis_ctr #(
    parameter int FLD_W    = 8,
    parameter int ACT_W    = 11,
    parameter bit PORCH_M1 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [FLD_W-1:0] f_sync,
    input  logic [FLD_W-1:0] f_back,
    input  logic [FLD_W-1:0] f_front,
    input  logic [ACT_W-1:0] f_act,
    output logic             in_sync,
    output logic             in_act,
    output logic             at_first,
    output logic             at_last,
    output logic [ACT_W-1:0] idx
);
    localparam int POS_W = ACT_W + 2;

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] len_sync;
    logic [POS_W-1:0] len_back;
    logic [POS_W-1:0] len_front;
    logic [POS_W-1:0] len_act;
    logic [POS_W-1:0] act_lo;
    logic [POS_W-1:0] act_hi;
    logic [POS_W-1:0] total;
    logic [POS_W-1:0] idx_full;

    assign len_sync = POS_W'(f_sync) + POS_W'(1);
    assign len_act  = POS_W'(f_act) + POS_W'(1);

    // Porch encoding chosen by parameter.
    generate
        if (PORCH_M1) begin : g_porch_m1
            assign len_back  = POS_W'(f_back) + POS_W'(1);
            assign len_front = POS_W'(f_front) + POS_W'(1);
        end else begin : g_porch_plain
            assign len_back  = POS_W'(f_back);
            assign len_front = POS_W'(f_front);
        end
    endgenerate

    // Phase boundaries inside the period.
    assign act_lo = len_sync + len_back;
    assign act_hi = act_lo + len_act;
    assign total  = act_hi + len_front;

    // Position decode.
    assign in_sync  = (pos < len_sync);
    assign in_act   = (pos >= act_lo) && (pos < act_hi);
    assign at_first = (pos == '0);
    assign at_last  = (pos == total - POS_W'(1));
    assign idx_full = pos - act_lo;
    assign idx      = in_act ? idx_full[ACT_W-1:0] : '0;

    // Position counter: cleared when idle, wraps at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_last ? '0 : pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/lcd_power_seq.sv
// Module: guarded power sequencer.
// Leaves OFF when pwr_en is high (start pulses for that cycle). When pwr_en
// falls, the current frame finishes and then guard_frames further frames
// run; busy falls after the frame_end of the last one. pwr_en returning
// during the guard cancels the stop.
// Assumes: frame_end is a single-cycle pulse on the last pixel enable of a
// frame and is only produced while busy.
module lcd_power_seq
    import lcd_sync_pkg::*;
#(
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_en,
    input  logic [GUARD_W-1:0] guard_frames,
    input  logic               frame_end,
    output logic               busy,
    output logic               start
);
    pwr_state_t         state;
    logic [GUARD_W-1:0] gcnt;

    assign busy  = (state != PS_OFF);
    assign start = (state == PS_OFF) && pwr_en;

    // State and guard-frame countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
            gcnt  <= '0;
        end else begin
            unique case (state)
                PS_OFF: begin
                    if (pwr_en) begin
                        state <= PS_RUN;
                    end
                end
                PS_RUN: begin
                    if (!pwr_en) begin
                        if (frame_end) begin
                            if (guard_frames == '0) begin
                                state <= PS_OFF;
                            end else begin
                                state <= PS_GUARD;
                                gcnt  <= guard_frames - GUARD_W'(1);
                            end
                        end else begin
                            state <= PS_GUARD;
                            gcnt  <= guard_frames;
                        end
                    end
                end
                PS_GUARD: begin
                    if (pwr_en) begin
                        state <= PS_RUN;
                    end else if (frame_end) begin
                        if (gcnt == '0) begin
                            state <= PS_OFF;
                        end else begin
                            gcnt <= gcnt - GUARD_W'(1);
                        end
                    end
                end
                default: state <= PS_OFF;
            endcase
        end
    end

endmodule

// File: rtl/lcd_sync_gen.sv
// Module: LCD sync timing generator (top).
// Joins the pixel divider, the horizontal and vertical axis counters and
// the power sequencer. Timing, polarity and display fields are copied into
// shadow registers at power-up and at every frame end; the axes only see
// the shadows. Outputs are decoded from registered state.
// Assumes: V_FLD_W <= V_ACT_W and H_FLD_W <= H_ACT_W.
module lcd_sync_gen #(
    parameter int DIV_W   = 8,
    parameter int GUARD_W = 4,
    parameter int H_FLD_W = 8,
    parameter int H_ACT_W = 11,
    parameter int V_FLD_W = 8,
    parameter int V_ACT_W = 10,
    parameter int BPP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_en,
    input  logic [GUARD_W-1:0] guard_frames,
    input  logic [DIV_W-1:0]   div_val,
    input  logic               div_bypass,
    input  logic [H_FLD_W-1:0] hs_width_m1,
    input  logic [H_FLD_W-1:0] hbp_m1,
    input  logic [H_FLD_W-1:0] hfp_m1,
    input  logic [H_ACT_W-1:0] h_act_m1,
    input  logic [V_FLD_W-1:0] vs_width_m1,
    input  logic [V_FLD_W-1:0] vbp_lines,
    input  logic [V_FLD_W-1:0] vfp_lines,
    input  logic [V_ACT_W-1:0] v_act_m1,
    input  logic               hsync_inv,
    input  logic               vsync_inv,
    input  logic               tft_sel,
    input  logic [BPP_W-1:0]   bpp_sel,
    output logic               pix_en,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [H_ACT_W-1:0] pix_x,
    output logic [V_ACT_W-1:0] line_y,
    output logic               frame_start,
    output logic               busy,
    output logic               disp_tft,
    output logic [BPP_W-1:0]   disp_bpp
);
    // Shadow copies of the programmed fields.
    logic [H_FLD_W-1:0] sh_hs, sh_hb, sh_hf;
    logic [H_ACT_W-1:0] sh_ha;
    logic [V_FLD_W-1:0] sh_vs, sh_vb, sh_vf;
    logic [V_ACT_W-1:0] sh_va;
    logic               sh_hinv, sh_vinv, sh_tft;
    logic [BPP_W-1:0]   sh_bpp;

    logic               pw_start;
    logic               frame_end;
    logic               shadow_load;
    logic               h_in_sync, h_in_act, h_first, h_last;
    logic               v_in_sync, v_in_act, v_first, v_last;
    logic [H_ACT_W-1:0] h_idx;
    logic [V_ACT_W-1:0] v_idx;

    lcd_power_seq #(
        .GUARD_W(GUARD_W)
    ) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_en      (pwr_en),
        .guard_frames(guard_frames),
        .frame_end   (frame_end),
        .busy        (busy),
        .start       (pw_start)
    );

    lcd_pixclk_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .bypass (div_bypass),
        .div_val(div_val),
        .tick   (pix_en)
    );

    // Horizontal axis: every field minus-one encoded.
    lcd_axis_ctr #(
        .FLD_W   (H_FLD_W),
        .ACT_W   (H_ACT_W),
        .PORCH_M1(1'b1)
    ) u_hax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!busy),
        .step    (pix_en),
        .f_sync  (sh_hs),
        .f_back  (sh_hb),
        .f_front (sh_hf),
        .f_act   (sh_ha),
        .in_sync (h_in_sync),
        .in_act  (h_in_act),
        .at_first(h_first),
        .at_last (h_last),
        .idx     (h_idx)
    );

    // Vertical axis: porches are plain line counts.
    lcd_axis_ctr #(
        .FLD_W   (V_FLD_W),
        .ACT_W   (V_ACT_W),
        .PORCH_M1(1'b0)
    ) u_vax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!busy),
        .step    (pix_en && h_last),
        .f_sync  (sh_vs),
        .f_back  (sh_vb),
        .f_front (sh_vf),
        .f_act   (sh_va),
        .in_sync (v_in_sync),
        .in_act  (v_in_act),
        .at_first(v_first),
        .at_last (v_last),
        .idx     (v_idx)
    );

    assign frame_end   = pix_en && h_last && v_last;
    assign shadow_load = pw_start || frame_end;

    // Shadow register capture at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hs   <= '0;
            sh_hb   <= '0;
            sh_hf   <= '0;
            sh_ha   <= '0;
            sh_vs   <= '0;
            sh_vb   <= '0;
            sh_vf   <= '0;
            sh_va   <= '0;
            sh_hinv <= 1'b0;
            sh_vinv <= 1'b0;
            sh_tft  <= 1'b0;
            sh_bpp  <= '0;
        end else if (shadow_load) begin
            sh_hs   <= hs_width_m1;
            sh_hb   <= hbp_m1;
            sh_hf   <= hfp_m1;
            sh_ha   <= h_act_m1;
            sh_vs   <= vs_width_m1;
            sh_vb   <= vbp_lines;
            sh_vf   <= vfp_lines;
            sh_va   <= v_act_m1;
            sh_hinv <= hsync_inv;
            sh_vinv <= vsync_inv;
            sh_tft  <= tft_sel;
            sh_bpp  <= bpp_sel;
        end
    end

    // Output decode; idle levels follow the live polarity inputs.
    always_comb begin
        if (busy) begin
            hsync  = h_in_sync ^ sh_hinv;
            vsync  = v_in_sync ^ sh_vinv;
            de     = h_in_act && v_in_act;
            pix_x  = h_idx;
            line_y = v_idx;
        end else begin
            hsync  = hsync_inv;
            vsync  = vsync_inv;
            de     = 1'b0;
            pix_x  = '0;
            line_y = '0;
        end
    end

    assign frame_start = pix_en && h_first && v_first;
    assign disp_tft    = sh_tft;
    assign disp_bpp    = sh_bpp;

endmodule

// File: rtl/lcd_sync_gen_sva.sv
// Module: assertion checker for lcd_sync_gen, attached by bind below.
// Assumes: connected to the top's ports plus the horizontal sync decode.
module lcd_sync_gen_sva #(
    parameter int H_ACT_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               pix_en,
    input logic               de,
    input logic               frame_start,
    input logic               div_bypass,
    input logic               h_in_sync,
    input logic [H_ACT_W-1:0] pix_x
);
    // R11: nothing moves while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pix_en && !de));

    // R3: bypass gives a pixel every cycle while running.
    a_r3_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div_bypass) |-> pix_en);

    // R2: a divided pixel enable is never two cycles wide.
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !div_bypass) |=> (!pix_en || div_bypass));

    // R6: data enable never overlaps the line sync.
    a_r6_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !h_in_sync);

    // R10: busy only falls right after a pixel enable (a frame end).
    a_r10_busy_falls_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pix_en));

    // R9: frame start marks a pixel enable.
    a_r9_start_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> pix_en);

    // R8: the column index only moves on a pixel enable.
    a_r8_x_holds_between_pixels: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_x));

endmodule

bind lcd_sync_gen lcd_sync_gen_sva #(
    .H_ACT_W(H_ACT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .pix_en     (pix_en),
    .de         (de),
    .frame_start(frame_start),
    .div_bypass (div_bypass),
    .h_in_sync  (h_in_sync),
    .pix_x      (pix_x)
);

// File: tb/lcd_sync_gen_test.sv
// Bench: scoreboard for lcd_sync_gen. A driver task predicts every pixel of
// a frame from the raw field values and queues it; a monitor pops one item
// on each pixel enable and compares.
module lcd_sync_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0;
    logic [3:0]  guard_frames = '0;
    logic [7:0]  div_val = '0;
    logic        div_bypass = 1'b0;
    logic [7:0]  hs_width_m1 = '0, hbp_m1 = '0, hfp_m1 = '0;
    logic [10:0] h_act_m1 = '0;
    logic [7:0]  vs_width_m1 = '0, vbp_lines = '0, vfp_lines = '0;
    logic [9:0]  v_act_m1 = '0;
    logic        hsync_inv = 1'b0, vsync_inv = 1'b0, tft_sel = 1'b0;
    logic [2:0]  bpp_sel = '0;
    logic        pix_en, hsync, vsync, de, frame_start, busy, disp_tft;
    logic [10:0] pix_x;
    logic [9:0]  line_y;
    logic [2:0]  disp_bpp;

    int checks = 0;
    int errors = 0;
    bit sb_on = 1'b1;

    typedef struct {
        int hs, hb, ha, hf, vs, vb, va, vf;
        bit hinv, vinv, tft;
        int bpp;
    } cfg_t;

    typedef struct packed {
        logic        hs;
        logic        vs;
        logic        de;
        logic [10:0] x;
        logic [9:0]  y;
        logic        fs;
        logic        tft;
        logic [2:0]  bpp;
    } item_t;

    item_t sb_q[$];

    lcd_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .guard_frames(guard_frames),
        .div_val(div_val), .div_bypass(div_bypass),
        .hs_width_m1(hs_width_m1), .hbp_m1(hbp_m1), .hfp_m1(hfp_m1), .h_act_m1(h_act_m1),
        .vs_width_m1(vs_width_m1), .vbp_lines(vbp_lines), .vfp_lines(vfp_lines),
        .v_act_m1(v_act_m1), .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
        .tft_sel(tft_sel), .bpp_sel(bpp_sel), .pix_en(pix_en), .hsync(hsync),
        .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y),
        .frame_start(frame_start), .busy(busy), .disp_tft(disp_tft), .disp_bpp(disp_bpp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input cfg_t c);
        hs_width_m1 = 8'(c.hs); hbp_m1 = 8'(c.hb); hfp_m1 = 8'(c.hf);
        h_act_m1 = 11'(c.ha);
        vs_width_m1 = 8'(c.vs); vbp_lines = 8'(c.vb); vfp_lines = 8'(c.vf);
        v_act_m1 = 10'(c.va);
        hsync_inv = c.hinv; vsync_inv = c.vinv; tft_sel = c.tft; bpp_sel = 3'(c.bpp);
    endtask

    // Driver: expected pixels of one frame (R4 R5 R6 R7 R8 R9).
    task automatic push_frame(input cfg_t c);
        int hsl = c.hs + 1, hbl = c.hb + 1, hal = c.ha + 1, hfl = c.hf + 1;
        int vsl = c.vs + 1, vbl = c.vb, val = c.va + 1, vfl = c.vf;
        for (int vp = 0; vp < vsl + vbl + val + vfl; vp++) begin
            for (int hp = 0; hp < hsl + hbl + hal + hfl; hp++) begin
                item_t it;
                bit hact = (hp >= hsl + hbl) && (hp < hsl + hbl + hal);
                bit vact = (vp >= vsl + vbl) && (vp < vsl + vbl + val);
                it.hs  = (hp < hsl) ^ c.hinv;
                it.vs  = (vp < vsl) ^ c.vinv;
                it.de  = hact && vact;
                it.x   = hact ? 11'(hp - hsl - hbl) : 11'd0;
                it.y   = vact ? 10'(vp - vsl - vbl) : 10'd0;
                it.fs  = (hp == 0) && (vp == 0);
                it.tft = c.tft;
                it.bpp = 3'(c.bpp);
                sb_q.push_back(it);
            end
        end
    endtask

    // Monitor: compare every produced pixel with the queue head.
    always @(negedge clk) begin
        if (rst_n && sb_on && pix_en) begin
            item_t got;
            got = '{hsync, vsync, de, pix_x, line_y, frame_start, disp_tft, disp_bpp};
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected pixel, actual %h expected none", got);
            end else begin
                item_t exp;
                exp = sb_q.pop_front();
                if (got !== exp) begin
                    errors++;
                    $display("FAIL R4/R5/R6/R7/R8/R9: actual %h expected %h", got, exp);
                end
            end
        end
    end

    task automatic measure_period(output int p);
        p = 0;
        while (!pix_en) @(negedge clk);
        @(negedge clk);
        p = 1;
        while (!pix_en) begin
            @(negedge clk);
            p++;
        end
    endtask

    task automatic wait_q(input int n);
        while (sb_q.size() > n) @(negedge clk);
    endtask

    task automatic stop_and_wait();
        pwr_en = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Idle quietness over a window (R11).
    task automatic idle_window(input int n, input bit hexp, input bit vexp);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pix_en || de || busy || hsync !== hexp || vsync !== vexp) bad++;
        end
        chk("R11 idle cycles with activity", bad, 0);
    endtask

    initial begin
        cfg_t ca, cb, cc;
        int p, fs_cnt, drops;
        ca = '{hs:1, hb:2, ha:7, hf:1, vs:0, vb:2, va:3, vf:1,
               hinv:1'b0, vinv:1'b0, tft:1'b1, bpp:4};
        cb = '{hs:1, hb:2, ha:5, hf:1, vs:0, vb:1, va:3, vf:1,
               hinv:1'b1, vinv:1'b1, tft:1'b0, bpp:2};
        cc = '{hs:0, hb:0, ha:3, hf:0, vs:1, vb:0, va:2, vf:0,
               hinv:1'b0, vinv:1'b1, tft:1'b1, bpp:7};

        // R1: reset state, with line sync inverted.
        hsync_inv = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 pix_en in reset", pix_en, 0);
        chk("R1 de in reset", de, 0);
        chk("R1 hsync idle level", hsync, 1);
        chk("R1 vsync idle level", vsync, 0);
        chk("R1 pix_x/line_y", pix_x + line_y, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 busy idle after reset", busy, 0);

        // R2 R4 R5 R8: two frames, timing rewritten mid-frame.
        apply_cfg(ca);
        div_val = 8'd1;
        guard_frames = 4'd0;
        push_frame(ca);
        push_frame(cb);
        pwr_en = 1'b1;
        measure_period(p);
        chk("R2 pixel period div=1", p, 4);
        wait_q(211 - 30);
        apply_cfg(cb);
        wait_q(10);
        stop_and_wait();
        chk("R10 frames left after stop, guard 0", sb_q.size(), 0);
        idle_window(40, 1'b1, 1'b1);

        // R3 R5: bypass, zero vertical porches.
        apply_cfg(cc);
        div_bypass = 1'b1;
        push_frame(cc);
        @(negedge clk);
        pwr_en = 1'b1;
        measure_period(p);
        chk("R3 bypass pixel period", p, 1);
        wait_q(10);
        stop_and_wait();
        chk("R10 frames left after bypass run", sb_q.size(), 0);
        div_bypass = 1'b0;

        // R10: guard of two frames.
        apply_cfg(ca);
        div_val = 8'd0;
        guard_frames = 4'd2;
        push_frame(ca);
        push_frame(ca);
        push_frame(ca);
        @(negedge clk);
        pwr_en = 1'b1;
        measure_period(p);
        chk("R2 pixel period div=0", p, 2);
        wait_q(360 - 20);
        pwr_en = 1'b0;
        fs_cnt = 0;
        while (busy) begin
            @(negedge clk);
            if (frame_start) fs_cnt++;
        end
        chk("R10 guarded frames started", fs_cnt, 2);
        chk("R10 queue drained at busy fall", sb_q.size(), 0);
        idle_window(20, 1'b0, 1'b0);

        // R12: pwr_en back during the guard keeps running.
        sb_on = 1'b0;
        guard_frames = 4'd3;
        @(negedge clk);
        pwr_en = 1'b1;
        repeat (40) @(negedge clk);
        pwr_en = 1'b0;
        while (!frame_start) @(negedge clk);
        pwr_en = 1'b1;
        drops = 0;
        fs_cnt = 0;
        while (fs_cnt < 5) begin
            @(negedge clk);
            if (!busy) drops++;
            if (frame_start) fs_cnt++;
        end
        chk("R12 busy drops after resume", drops, 0);
        guard_frames = 4'd0;
        stop_and_wait();
        idle_window(20, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule